// File: doc/BRIEF.md
# Interrupt Vector Router with Selectable Route Encoding

The router accepts a vector of level-sensitive interrupt inputs (256 by default) and steers each one that is asserted and enabled to a single CPU interrupt pin. Each pin is one bit of a flat output array that holds one group of 16 pins per implemented CPU. Software programs the router through a 32-bit register port. The register space holds a mask of per-vector enable bits, a read-only snapshot of which vectors are both asserted and enabled, an 8-bit CPU target per vector, and a 4-bit pin selector shared by each group of 32 vectors.

There are two ways to read a route. The legacy decoding treats the upper nibble of the CPU target as a node number and the lower nibble as a CPU bitmap, and it treats the pin selector as a pin bitmap. This reaches at most four CPUs and four pins within this router's node. The binary decoding treats the CPU target as a CPU number from 0 to 255 and the pin selector as a pin number from 0 to 15. A read-only capability word states which decodings this instance supports. A configuration word chooses the active decoding and, when the option exists, gates every output on or off. The configuration resets to zero, so after reset the router uses the legacy decoding.

Top module: `vr_router`

## Requirements
- R1: The capability word at byte address 0x4000_0000 reads bit 0 = 1, bit 1 = HAS_EN_OPT, bit 2 = HAS_PIN_ENC, bit 3 = HAS_CPU_ENC and all other bits 0. Writes to it change nothing.
- R2: The configuration word at 0x4000_0004 resets to 0. Bit 1 (output gate), bit 2 (binary pin decoding) and bit 3 (binary CPU decoding) store the written value only when the matching capability bit is 1. Otherwise, and for all other bits, they read 0.
- R3: Vector v's enable bit is bit v&31 of the word at 0x1600 + (v>>5)*4. All enable bits reset to 0.
- R4: Vector v's 8-bit CPU target occupies bits (v&3)*8+7 down to (v&3)*8 of the word at 0x1C00 + (v & ~3). Every target resets to 0x01, which in legacy decoding is CPU0 of node 0.
- R5: The pin selector of group g = v>>5 is bits 3:0 of byte g&3 of the word at 0x1400 + (g>>2)*4. The upper four bits of each byte read 0. Each selector resets to 0x1, which in legacy decoding is pin 0.
- R6: Status bit v of the word at 0x1800 + (v>>5)*4 reads as (input v AND enable v), sampled at the clock edge before the read is accepted. Writes to it are ignored.
- R7: In legacy CPU decoding a vector reaches CPU c (c < 4) only when target bits 7:4 equal NODE_ID and target bit c is 1. Several set bits reach several CPUs.
- R8: In legacy pin decoding, pin p (p < 4) is reached when selector bit p is 1.
- R9: In binary CPU decoding the target is a CPU number. A number at or above NUM_CPU reaches nothing.
- R10: In binary pin decoding the selector is a pin number from 0 to 15.
- R11: Output bit cpu*16+pin is the OR of every vector that is asserted, enabled and routed there. It is registered, so it reflects inputs and registers one clock later. It is forced to 0 while HAS_EN_OPT = 1 and configuration bit 1 = 0.
- R12: A read accepted at one clock edge places its data on rdata at that edge. rdata holds that value until the next read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 32 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| vec_in | input | NUM_VEC | Level interrupt inputs |
| irq_out | output | NUM_CPU*16 | Per-CPU, per-pin interrupt outputs, bit cpu*16+pin |

## Verification
The hardest situation to reach is a live decoding switch: a set of vectors routed with one decoding is reinterpreted under the other. This can send a vector to a CPU above 3, to a pin above 3, or to nowhere when its number is out of range. The stimulus reaches it by programming targets and selectors in legacy decoding and then flipping the configuration to binary decoding while the same inputs stay asserted. A second instance built with no capabilities confirms that configuration writes are masked. A random phase follows that mixes register writes, including writes that toggle the decoding, with dense input patterns, and it is compared against a behavioural model on every clock.

// File: rtl/vr_pkg.sv
package vr_pkg;
  localparam int ROUTE_W = 8;
  localparam int PIN_W   = 4;
  localparam int NUM_PIN = 1 << PIN_W;
  localparam int GRP_SZ  = 32;
  localparam int LANE_W  = 8;

  localparam logic [31:0] PIN_BASE   = 32'h0000_1400;
  localparam logic [31:0] EN_BASE    = 32'h0000_1600;
  localparam logic [31:0] STAT_BASE  = 32'h0000_1800;
  localparam logic [31:0] ROUTE_BASE = 32'h0000_1C00;
  localparam logic [31:0] CAP_ADDR   = 32'h4000_0000;
  localparam logic [31:0] CFG_ADDR   = 32'h4000_0004;

  typedef struct packed {
    logic drive;
    logic pin_enc;
    logic cpu_enc;
  } mode_t;
endpackage

// File: rtl/vr_regs.sv
module vr_regs
  import vr_pkg::*;
#(
  parameter int NUM_VEC     = 256,
  parameter bit HAS_EN_OPT  = 1'b1,
  parameter bit HAS_PIN_ENC = 1'b1,
  parameter bit HAS_CPU_ENC = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [31:0]                 addr,
  input  logic [31:0]                 wdata,
  output logic [31:0]                 rdata,
  input  logic [NUM_VEC-1:0]          vec_in,
  output logic [NUM_VEC-1:0]          en_o,
  output logic [NUM_VEC*ROUTE_W-1:0]  route_o,
  output logic [(NUM_VEC/GRP_SZ)*PIN_W-1:0] pin_o,
  output mode_t                       mode_o
);
  localparam int NUM_GRP    = NUM_VEC / GRP_SZ;
  localparam int RT_PER_REG = 32 / LANE_W;
  localparam int RT_REGS    = NUM_VEC / RT_PER_REG;
  localparam int PIN_REGS   = (NUM_GRP + RT_PER_REG - 1) / RT_PER_REG;
  localparam logic [3:1] CFG_MASK = {HAS_CPU_ENC, HAS_PIN_ENC, HAS_EN_OPT};
  localparam logic [31:0] CAP_VAL = {28'd0, HAS_CPU_ENC, HAS_PIN_ENC, HAS_EN_OPT, 1'b1};

  logic [NUM_VEC-1:0] en_q, stat_q;
  logic [ROUTE_W-1:0] route_q [NUM_VEC];
  logic [PIN_W-1:0]   pin_q   [NUM_GRP];
  logic [3:1]         cfg_q;

  logic hit_en, hit_st, hit_rt, hit_pn, hit_cap, hit_cfg, map_hit;
  logic [29:0] en_idx, st_idx, rt_idx, pn_idx;

  assign hit_en  = (addr >= EN_BASE)    && (addr < EN_BASE    + 32'(4*NUM_GRP));
  assign hit_st  = (addr >= STAT_BASE)  && (addr < STAT_BASE  + 32'(4*NUM_GRP));
  assign hit_rt  = (addr >= ROUTE_BASE) && (addr < ROUTE_BASE + 32'(4*RT_REGS));
  assign hit_pn  = (addr >= PIN_BASE)   && (addr < PIN_BASE   + 32'(4*PIN_REGS));
  assign hit_cap = (addr == CAP_ADDR);
  assign hit_cfg = (addr == CFG_ADDR);
  assign map_hit = hit_en | hit_st | hit_rt | hit_pn | hit_cap | hit_cfg;

  assign en_idx = addr[31:2] - EN_BASE[31:2];
  assign st_idx = addr[31:2] - STAT_BASE[31:2];
  assign rt_idx = addr[31:2] - ROUTE_BASE[31:2];
  assign pn_idx = addr[31:2] - PIN_BASE[31:2];

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      cfg_q <= '0;
      for (int v = 0; v < NUM_VEC; v++) route_q[v] <= ROUTE_W'(1);
      for (int g = 0; g < NUM_GRP; g++) pin_q[g] <= PIN_W'(1);
    end else if (wr_en) begin
      if (hit_cfg) cfg_q <= wdata[3:1] & CFG_MASK;
      if (hit_en)
        for (int k = 0; k < NUM_GRP; k++)
          if (en_idx == 30'(k)) en_q[k*GRP_SZ +: GRP_SZ] <= wdata;
      if (hit_rt)
        for (int k = 0; k < RT_REGS; k++)
          if (rt_idx == 30'(k))
            for (int j = 0; j < RT_PER_REG; j++)
              route_q[k*RT_PER_REG+j] <= wdata[j*LANE_W +: ROUTE_W];
      if (hit_pn)
        for (int g = 0; g < NUM_GRP; g++)
          if (pn_idx == 30'(g / RT_PER_REG))
            pin_q[g] <= wdata[(g % RT_PER_REG)*LANE_W +: PIN_W];
    end
  end

  // live status snapshot
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= vec_in & en_q;
  end

  // read path
  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (hit_cap) rd_val = CAP_VAL;
    if (hit_cfg) rd_val = {28'd0, cfg_q, 1'b0};
    if (hit_en)
      for (int k = 0; k < NUM_GRP; k++)
        if (en_idx == 30'(k)) rd_val = en_q[k*GRP_SZ +: GRP_SZ];
    if (hit_st)
      for (int k = 0; k < NUM_GRP; k++)
        if (st_idx == 30'(k)) rd_val = stat_q[k*GRP_SZ +: GRP_SZ];
    if (hit_rt)
      for (int k = 0; k < RT_REGS; k++)
        if (rt_idx == 30'(k))
          for (int j = 0; j < RT_PER_REG; j++)
            rd_val[j*LANE_W +: ROUTE_W] = route_q[k*RT_PER_REG+j];
    if (hit_pn)
      for (int g = 0; g < NUM_GRP; g++)
        if (pn_idx == 30'(g / RT_PER_REG))
          rd_val[(g % RT_PER_REG)*LANE_W +: PIN_W] = pin_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  // flatten state toward the steering logic
  assign en_o = en_q;
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_rt
    assign route_o[v*ROUTE_W +: ROUTE_W] = route_q[v];
  end
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pn
    assign pin_o[g*PIN_W +: PIN_W] = pin_q[g];
  end
  assign mode_o.drive   = HAS_EN_OPT ? cfg_q[1] : 1'b1;
  assign mode_o.pin_enc = cfg_q[2];
  assign mode_o.cpu_enc = cfg_q[3];

  AST_CFG_MASKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CFG_ADDR) |=> (cfg_q == ($past(wdata[3:1]) & CFG_MASK))); // R2
  AST_ROUTE_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (route_q[0] == ROUTE_W'(1) && pin_q[0] == PIN_W'(1))); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !map_hit) |=> (rdata == '0)); // R12
endmodule

// File: rtl/vr_steer.sv
module vr_steer
  import vr_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int NUM_CPU = 8,
  parameter int NODE_ID = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  mode_t                       mode,
  input  logic [NUM_VEC-1:0]          vec_in,
  input  logic [NUM_VEC-1:0]          en_i,
  input  logic [NUM_VEC*ROUTE_W-1:0]  route_i,
  input  logic [(NUM_VEC/GRP_SZ)*PIN_W-1:0] pin_i,
  output logic [NUM_CPU*NUM_PIN-1:0]  irq_out
);
  localparam int NODE_W = ROUTE_W / 2;
  localparam int BMAP_W = ROUTE_W - NODE_W;

  function automatic logic [NUM_CPU-1:0] cpu_sel(input logic [ROUTE_W-1:0] rt, input logic enc);
    logic [NUM_CPU-1:0] h;
    h = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (enc) h[c] = (32'(rt) == c);
      else if (c < BMAP_W)
        h[c] = (rt[ROUTE_W-1:BMAP_W] == NODE_W'(NODE_ID)) && rt[c];
    end
    return h;
  endfunction

  function automatic logic [NUM_PIN-1:0] pin_sel(input logic [PIN_W-1:0] ps, input logic enc);
    logic [NUM_PIN-1:0] h;
    h = '0;
    for (int p = 0; p < NUM_PIN; p++) begin
      if (enc) h[p] = (32'(ps) == p);
      else if (p < PIN_W) h[p] = ps[p];
    end
    return h;
  endfunction

  logic [NUM_VEC-1:0] act;
  logic [NUM_CPU-1:0] cpu_hit [NUM_VEC];
  logic [NUM_PIN-1:0] pin_hit [NUM_VEC];

  assign act = vec_in & en_i;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign cpu_hit[v] = cpu_sel(route_i[v*ROUTE_W +: ROUTE_W], mode.cpu_enc);
    assign pin_hit[v] = pin_sel(pin_i[(v/GRP_SZ)*PIN_W +: PIN_W], mode.pin_enc);
  end

  logic [NUM_CPU*NUM_PIN-1:0] any;
  always_comb begin
    any = '0;
    for (int v = 0; v < NUM_VEC; v++)
      for (int c = 0; c < NUM_CPU; c++)
        if (act[v] && cpu_hit[v][c])
          any[c*NUM_PIN +: NUM_PIN] = any[c*NUM_PIN +: NUM_PIN] | pin_hit[v];
  end

  always_ff @(posedge clk) begin
    if (rst)             irq_out <= '0;
    else if (mode.drive) irq_out <= any;
    else                 irq_out <= '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (act == '0) |=> (irq_out == '0)); // R11
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
    (!mode.drive) |=> (irq_out == '0)); // R11
endmodule

// File: rtl/vr_router.sv
module vr_router
  import vr_pkg::*;
#(
  parameter int NUM_VEC     = 256,
  parameter int NUM_CPU     = 8,
  parameter int NODE_ID     = 0,
  parameter bit HAS_EN_OPT  = 1'b1,
  parameter bit HAS_PIN_ENC = 1'b1,
  parameter bit HAS_CPU_ENC = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [31:0]                addr,
  input  logic [31:0]                wdata,
  output logic [31:0]                rdata,
  input  logic [NUM_VEC-1:0]         vec_in,
  output logic [NUM_CPU*NUM_PIN-1:0] irq_out
);
  localparam int NUM_GRP = NUM_VEC / GRP_SZ;

  logic [NUM_VEC-1:0]         en_w;
  logic [NUM_VEC*ROUTE_W-1:0] route_w;
  logic [NUM_GRP*PIN_W-1:0]   pin_w;
  mode_t                      mode_w;

  vr_regs #(
    .NUM_VEC(NUM_VEC), .HAS_EN_OPT(HAS_EN_OPT),
    .HAS_PIN_ENC(HAS_PIN_ENC), .HAS_CPU_ENC(HAS_CPU_ENC)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .vec_in(vec_in), .en_o(en_w),
    .route_o(route_w), .pin_o(pin_w), .mode_o(mode_w)
  );

  vr_steer #(
    .NUM_VEC(NUM_VEC), .NUM_CPU(NUM_CPU), .NODE_ID(NODE_ID)
  ) u_steer (
    .clk(clk), .rst(rst), .mode(mode_w), .vec_in(vec_in), .en_i(en_w),
    .route_i(route_w), .pin_i(pin_w), .irq_out(irq_out)
  );
endmodule

// File: tb/vr_router_tb.sv
module vr_router_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 256;
  localparam int NC    = 8;
  localparam int NO    = NC * 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata, nf_rdata;
  logic [NV-1:0] vec_in = '0;
  logic [NO-1:0] irq_out, nf_irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  vr_router u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .vec_in(vec_in), .irq_out(irq_out)
  );

  vr_router #(.HAS_EN_OPT(1'b0), .HAS_PIN_ENC(1'b0), .HAS_CPU_ENC(1'b0)) u_dut_nf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(nf_rdata), .vec_in(vec_in), .irq_out(nf_irq)
  );

  // behavioural reference model of u_dut
  logic [7:0]    m_rt [NV];
  logic          m_en [NV];
  logic [3:0]    m_pn [8];
  logic [3:1]    m_cfg;
  logic [NV-1:0] m_stat;
  logic [NO-1:0] exp_irq;
  logic [31:0]   exp_rd;
  bit            rd_pend;

  function automatic logic [NO-1:0] model_irq();
    logic [NO-1:0] r = '0;
    if (!m_cfg[1]) return r;
    for (int v = 0; v < NV; v++) begin
      if (vec_in[v] && m_en[v]) begin
        int g = v / 32;
        for (int c = 0; c < NC; c++) begin
          bit hc;
          if (m_cfg[3]) hc = (int'(m_rt[v]) == c);
          else hc = (c < 4) && (m_rt[v][7:4] == 4'd0) && m_rt[v][c];
          if (hc)
            for (int p = 0; p < 16; p++) begin
              bit hp;
              if (m_cfg[2]) hp = (int'(m_pn[g]) == p);
              else hp = (p < 4) && m_pn[g][p];
              if (hp) r[c*16+p] = 1'b1;
            end
        end
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] model_read(input logic [31:0] a);
    logic [31:0] r = '0;
    if (a == 32'h4000_0000) r = 32'hF;
    else if (a == 32'h4000_0004) r = {28'd0, m_cfg, 1'b0};
    else if (a >= 32'h1600 && a < 32'h1620)
      for (int b = 0; b < 32; b++) r[b] = m_en[(a - 32'h1600) / 4 * 32 + b];
    else if (a >= 32'h1800 && a < 32'h1820)
      r = m_stat[(a - 32'h1800) / 4 * 32 +: 32];
    else if (a >= 32'h1C00 && a < 32'h1D00)
      for (int j = 0; j < 4; j++) r[j*8 +: 8] = m_rt[(a - 32'h1C00) / 4 * 4 + j];
    else if (a >= 32'h1400 && a < 32'h1408)
      for (int j = 0; j < 4; j++) r[j*8 +: 4] = m_pn[(a - 32'h1400) / 4 * 4 + j];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int v = 0; v < NV; v++) begin m_rt[v] = 8'h01; m_en[v] = 1'b0; end
      for (int g = 0; g < 8; g++) m_pn[g] = 4'h1;
      m_cfg = '0; m_stat = '0; exp_irq = '0; rd_pend = 1'b0;
    end else begin
      exp_irq = model_irq();
      rd_pend = rd_en;
      if (rd_en) exp_rd = model_read(addr);
      for (int v = 0; v < NV; v++) m_stat[v] = vec_in[v] & m_en[v];
      if (wr_en) begin
        if (addr == 32'h4000_0004) m_cfg = wdata[3:1];
        else if (addr >= 32'h1600 && addr < 32'h1620)
          for (int b = 0; b < 32; b++) m_en[(addr - 32'h1600) / 4 * 32 + b] = wdata[b];
        else if (addr >= 32'h1C00 && addr < 32'h1D00)
          for (int j = 0; j < 4; j++) m_rt[(addr - 32'h1C00) / 4 * 4 + j] = wdata[j*8 +: 8];
        else if (addr >= 32'h1400 && addr < 32'h1408)
          for (int j = 0; j < 4; j++) m_pn[(addr - 32'h1400) / 4 * 4 + j] = wdata[j*8 +: 4];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [NO-1:0] act, input logic [NO-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(irq_out === exp_irq, "R11 model irq_out", irq_out, exp_irq);
      if (rd_pend) chk(rdata === exp_rd, "R12 model rdata", NO'(rdata), NO'(exp_rd));
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk(rdata === e, tag, NO'(rdata), NO'(e));
  endtask

  task automatic rd_nf(input logic [31:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk(nf_rdata === e, tag, NO'(nf_rdata), NO'(e));
  endtask

  function automatic logic [NO-1:0] bits(input int a, input int b = -1, input int c = -1, input int d = -1);
    logic [NO-1:0] r = '0;
    r[a] = 1'b1;
    if (b >= 0) r[b] = 1'b1;
    if (c >= 0) r[c] = 1'b1;
    if (d >= 0) r[d] = 1'b1;
    return r;
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(irq_out === '0, "R11 reset outputs", irq_out, '0);
    rd(32'h4000_0000, 32'hF, "R1 capability word");
    rd(32'h4000_0004, 32'h0, "R2 config reset");
    rd(32'h1C00, 32'h01010101, "R4 route reset");
    rd(32'h1400, 32'h01010101, "R5 pin selector reset");
    rd(32'h161C, 32'h0, "R3 enable reset");
    wr(32'h4000_0000, 32'h0);
    rd(32'h4000_0000, 32'hF, "R1 capability write ignored");

    // vector 5, default route, gate still off
    vec_in[5] = 1'b1;
    wr(32'h1600, 32'h20);
    @(negedge clk);
    chk(irq_out === '0, "R11 gate off", irq_out, '0);
    chk(nf_irq === bits(0), "R11 no gate option", nf_irq, bits(0));
    wr(32'h4000_0004, 32'h2);
    @(negedge clk);
    chk(irq_out === bits(0), "R4 reset route CPU0 pin0", irq_out, bits(0));
    rd(32'h1800, 32'h20, "R6 status");
    wr(32'h1800, 32'h0);
    rd(32'h1800, 32'h20, "R6 status write ignored");

    // legacy bitmap decoding
    wr(32'h1C04, 32'h01010601);
    wr(32'h1400, 32'h0101010A);
    @(negedge clk);
    chk(irq_out === bits(17, 19, 33, 35), "R7 R8 bitmap cpus 1,2 pins 1,3", irq_out, bits(17, 19, 33, 35));
    wr(32'h1C04, 32'h01011601);
    @(negedge clk);
    chk(irq_out === '0, "R7 node mismatch", irq_out, '0);

    // vector 255 on CPU3 pin0 merged with vector 5 on CPU1
    wr(32'h1C04, 32'h01010201);
    wr(32'h1CFC, 32'h08010101);
    wr(32'h161C, 32'h80000000);
    vec_in[255] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(irq_out === bits(17, 19, 48), "R3 R11 top vector merged", irq_out, bits(17, 19, 48));

    // switch to binary decoding with the same inputs
    wr(32'h4000_0004, 32'hE);
    @(negedge clk);
    chk(irq_out === bits(42), "R9 R10 binary cpu2 pin10, cpu8 unreached", irq_out, bits(42));
    rd(32'h4000_0004, 32'hE, "R2 config readback");
    rd_nf(32'h4000_0004, 32'h0, "R2 masked config");
    rd_nf(32'h4000_0000, 32'h1, "R1 capability without options");
    wr(32'h1CFC, 32'h07010101);
    @(negedge clk);
    chk(irq_out === bits(42, 113), "R9 binary cpu7", irq_out, bits(42, 113));
    rd(32'h1CFC, 32'h07010101, "R4 route readback");
    rd(32'h0001_0000, 32'h0, "R12 unmapped read");
    wr(32'h1600, 32'h0);
    @(negedge clk);
    chk(irq_out === bits(113), "R3 disable vector", irq_out, bits(113));

    // random phase
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      for (int w = 0; w < NV / 32; w++) vec_in[w*32 +: 32] = $urandom & $urandom;
      wr_en = ($urandom % 3) == 0;
      rd_en = !wr_en && (($urandom % 3) == 0);
      wdata = $urandom;
      case ($urandom % 6)
        0: addr = 32'h1600 + 4 * ($urandom % 8);
        1: begin
          addr = 32'h1C00 + 4 * ($urandom % 64);
          wdata = wdata & (($urandom % 2) ? 32'h07070707 : 32'h0F0F0F0F);
        end
        2: addr = 32'h1400 + 4 * ($urandom % 2);
        3: begin
          addr = 32'h4000_0004;
          wdata = (wdata & 32'hF) | ((i % 4 != 0) ? 32'h2 : 32'h0);
        end
        4: addr = 32'h1800 + 4 * ($urandom % 8);
        default: addr = ($urandom % 2) ? 32'h4000_0000 : 32'h0000_2000;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule